// File: doc/BRIEF.md
# Sample Transform Unit

This block takes a stream of 10-bit converter results, keeps the eight most significant bits of each one, and applies one of four arithmetic transforms before handing the 8-bit result to a downstream converter stream. The four transforms are doubling with saturation, halving, inversion against full scale, and clamping into a programmable window. Each input sample carries a valid strobe. The result appears one clock later with its own valid strobe.

The transform is picked per sample by a 2-bit mode input. The two clamp limits are taken in the same cycle as the sample. A two-state output machine tracks whether the output register holds a sample that is fresh this cycle. In state `ST_EMPTY`, no new result is present. In state `ST_FULL`, a result was loaded on the last edge.

The machine has four transitions:
- `ST_EMPTY -> ST_FULL` when `in_valid` is high.
- `ST_FULL -> ST_FULL` when samples arrive back to back.
- `ST_FULL -> ST_EMPTY` when `in_valid` is low.
- `ST_EMPTY -> ST_EMPTY` while the input stays idle.

Reset enters `ST_EMPTY`.

Top module: `sample_xform`

## Requirements
- R1: During and right after reset, `out_valid` is 0 and `out_sample` is 0x00.
- R2: `out_valid` is high in exactly those cycles that follow a cycle with `in_valid` high, which gives one cycle of latency.
- R3: Only bits [9:2] of `in_sample` take part in the result. The two lowest bits have no effect on `out_sample`.
- R4: Mode 0 (double) outputs twice the reduced value, and saturates at 0xFF when that would exceed 0xFF.
- R5: Mode 1 (halve) outputs the reduced value shifted right by one.
- R6: Mode 2 (invert) outputs 0xFF minus the reduced value.
- R7: Mode 3 (clip) with `clip_lo` <= `clip_hi` outputs `clip_lo` for values below it, `clip_hi` for values above it, and the value itself otherwise. Values equal to a limit pass unchanged.
- R8: Mode 3 with `clip_lo` > `clip_hi` passes the reduced value through unchanged.
- R9: Mode and limits are taken in the cycle `in_valid` is high. When `in_valid` is low, `out_sample` keeps its previous value, whatever the mode and limit inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | 10 | Raw converter result |
| in_mode | input | 2 | Transform select: 0 double, 1 halve, 2 invert, 3 clip |
| clip_lo | input | 8 | Lower clamp limit for mode 3 |
| clip_hi | input | 8 | Upper clamp limit for mode 3 |
| out_valid | output | 1 | Result strobe |
| out_sample | output | 8 | Transformed 8-bit result |

## Verification
Directed inputs are applied at zero, full scale and the half-scale crossing in every mode. This separates saturation in double mode from wrap-around, and it exposes off-by-one errors in invert against full scale. Clip mode is tried with values below the window, on each limit, inside it and above it, and then with swapped limits, to tell clamping apart from pass-through. A pair of inputs that differ only in the two lowest bits shows that truncation rather than rounding is used. Back-to-back, gapped and random sequences with changing mode and limits show when mode and limits are taken and that the output holds between samples.

// File: rtl/sxf_pkg.sv
package sxf_pkg;

    typedef enum logic [1:0] {
        XF_DOUBLE = 2'd0,
        XF_HALVE  = 2'd1,
        XF_INVERT = 2'd2,
        XF_CLIP   = 2'd3
    } xf_mode_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } out_state_e;

endpackage

// File: rtl/sxf_narrow.sv
module sxf_narrow #(
    parameter int IN_W  = 10,
    parameter int OUT_W = 8
) (
    input  logic [IN_W-1:0]  raw_word,
    output logic [OUT_W-1:0] narrow_word
);
    localparam int DROP = (IN_W > OUT_W) ? IN_W - OUT_W : 0;

    generate
        if (IN_W >= OUT_W) begin : g_cut
            // keep the top bits, discard DROP least significant bits
            assign narrow_word = raw_word[IN_W-1 -: OUT_W];
        end else begin : g_pad
            assign narrow_word = {raw_word, {(OUT_W-IN_W){1'b0}}};
        end
    endgenerate

    logic unused_low;
    assign unused_low = (DROP > 0) ? ^raw_word : 1'b0;
endmodule

// File: rtl/sxf_transform.sv
module sxf_transform
    import sxf_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] value,
    input  xf_mode_e     mode,
    input  logic [W-1:0] lo_lim,
    input  logic [W-1:0] hi_lim,
    output logic [W-1:0] result
);
    localparam logic [W-1:0] FULL = {W{1'b1}};

    logic [W:0]   doubled_wide;
    logic [W-1:0] doubled_sat;
    logic [W-1:0] halved;
    logic [W-1:0] inverted;
    logic [W-1:0] clipped;

    assign doubled_wide = {value, 1'b0};
    assign doubled_sat  = doubled_wide[W] ? FULL : doubled_wide[W-1:0];
    assign halved       = value >> 1;
    assign inverted     = FULL - value;

    always_comb begin
        if (lo_lim > hi_lim)      clipped = value;
        else if (value < lo_lim)  clipped = lo_lim;
        else if (value > hi_lim)  clipped = hi_lim;
        else                      clipped = value;
    end

    always_comb begin
        unique case (mode)
            XF_DOUBLE: result = doubled_sat;
            XF_HALVE:  result = halved;
            XF_INVERT: result = inverted;
            XF_CLIP:   result = clipped;
        endcase
    end
endmodule

// File: rtl/sample_xform.sv
module sample_xform
    import sxf_pkg::*;
#(
    parameter int IN_W  = 10,
    parameter int OUT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_sample,
    input  logic [1:0]       in_mode,
    input  logic [OUT_W-1:0] clip_lo,
    input  logic [OUT_W-1:0] clip_hi,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_sample
);
    out_state_e      state_q, state_d;
    logic [OUT_W-1:0] narrow_val;
    logic [OUT_W-1:0] xf_result;
    logic [OUT_W-1:0] sample_q;

    sxf_narrow #(.IN_W(IN_W), .OUT_W(OUT_W)) u_narrow (
        .raw_word    (in_sample),
        .narrow_word (narrow_val)
    );

    sxf_transform #(.W(OUT_W)) u_xf (
        .value  (narrow_val),
        .mode   (xf_mode_e'(in_mode)),
        .lo_lim (clip_lo),
        .hi_lim (clip_hi),
        .result (xf_result)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: state_d = in_valid ? ST_FULL : ST_EMPTY;
            ST_FULL:  state_d = in_valid ? ST_FULL : ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        sample_q <= '0;
        else if (in_valid) sample_q <= xf_result;
    end

    always_comb begin
        out_valid  = (state_q == ST_FULL);
        out_sample = sample_q;
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_sample)); // R9
    AST_DOUBLE_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == 2'd0 && in_sample[IN_W-1]) |=> (out_sample == {OUT_W{1'b1}})); // R4
    AST_HALVE_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == 2'd1) |=> !out_sample[OUT_W-1]); // R5
    AST_CLIP_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == 2'd3 && clip_lo <= clip_hi)
        |=> (out_sample >= $past(clip_lo) && out_sample <= $past(clip_hi))); // R7
endmodule

// File: tb/sample_xform_test.sv
`timescale 1ns/1ps
module sample_xform_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [9:0] in_sample = '0;
    logic [1:0] in_mode = '0;
    logic [7:0] clip_lo = '0;
    logic [7:0] clip_hi = '0;
    logic       out_valid;
    logic [7:0] out_sample;

    int n_checks = 0;
    int n_fail = 0;

    logic       exp_valid = 1'b0;
    logic [7:0] exp_sample = '0;
    string      exp_tag = "R1";

    always #10 clk = ~clk;

    sample_xform uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .in_mode(in_mode), .clip_lo(clip_lo), .clip_hi(clip_hi),
        .out_valid(out_valid), .out_sample(out_sample)
    );

    function automatic int ref_xf(int raw, int mode, int lo, int hi);
        int v;
        v = raw / 4;
        case (mode)
            0: return (2 * v > 255) ? 255 : 2 * v;
            1: return v / 2;
            2: return 255 - v;
            default: begin
                if (lo > hi) return v;
                if (v < lo) return lo;
                if (v > hi) return hi;
                return v;
            end
        endcase
    endfunction

    function automatic string ref_tag(int mode, int lo, int hi);
        case (mode)
            0: return "R4";
            1: return "R5";
            2: return "R6";
            default: return (lo > hi) ? "R8" : "R7";
        endcase
    endfunction

    task automatic check(string tag, int actual, int expected);
        n_checks++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, actual, expected, $time);
        end
    endtask

    // behavioural reference, updated at every edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_valid  <= 1'b0;
            exp_sample <= 8'h00;
            exp_tag    <= "R1";
        end else begin
            exp_valid <= in_valid;
            if (in_valid) begin
                exp_sample <= 8'(ref_xf(int'(in_sample), int'(in_mode), int'(clip_lo), int'(clip_hi)));
                exp_tag    <= ref_tag(int'(in_mode), int'(clip_lo), int'(clip_hi));
            end else begin
                exp_tag <= "R9";
            end
        end
    end

    always @(negedge clk) begin
        check(rst_n ? "R2" : "R1", int'(out_valid), int'(exp_valid));
        check(exp_tag, int'(out_sample), int'(exp_sample));
    end

    task automatic push(logic [9:0] s, logic [1:0] m, logic [7:0] lo, logic [7:0] hi);
        in_valid = 1'b1; in_sample = s; in_mode = m; clip_lo = lo; clip_hi = hi;
        @(negedge clk);
    endtask

    task automatic idle(int n);
        in_valid = 1'b0;
        for (int i = 0; i < n; i++) begin
            in_sample = 10'($urandom); in_mode = 2'($urandom);
            clip_lo = 8'($urandom); clip_hi = 8'($urandom);
            @(negedge clk);
        end
    endtask

    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] first;
        repeat (3) @(negedge clk);
        check("R1", int'(out_valid), 0);
        check("R1", int'(out_sample), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", int'(out_sample), 0);

        // double: zero, just below half, half, full
        push(10'h000, 2'd0, 0, 0); check("R4", int'(out_sample), 8'h00);
        push(10'h1FF, 2'd0, 0, 0); check("R4", int'(out_sample), 8'hFE);
        push(10'h200, 2'd0, 0, 0); check("R4", int'(out_sample), 8'hFF);
        push(10'h3FF, 2'd0, 0, 0); check("R4", int'(out_sample), 8'hFF);
        // halve
        push(10'h3FF, 2'd1, 0, 0); check("R5", int'(out_sample), 8'h7F);
        push(10'h00C, 2'd1, 0, 0); check("R5", int'(out_sample), 8'h01);
        // invert
        push(10'h000, 2'd2, 0, 0); check("R6", int'(out_sample), 8'hFF);
        push(10'h3FF, 2'd2, 0, 0); check("R6", int'(out_sample), 8'h00);
        push(10'h228, 2'd2, 0, 0); check("R6", int'(out_sample), 8'h75);
        // clip window 0x40..0xC0
        push(10'h040, 2'd3, 8'h40, 8'hC0); check("R7", int'(out_sample), 8'h40);
        push(10'h100, 2'd3, 8'h40, 8'hC0); check("R7", int'(out_sample), 8'h40);
        push(10'h200, 2'd3, 8'h40, 8'hC0); check("R7", int'(out_sample), 8'h80);
        push(10'h300, 2'd3, 8'h40, 8'hC0); check("R7", int'(out_sample), 8'hC0);
        push(10'h3FC, 2'd3, 8'h40, 8'hC0); check("R7", int'(out_sample), 8'hC0);
        // swapped limits
        push(10'h040, 2'd3, 8'hC0, 8'h40); check("R8", int'(out_sample), 8'h10);
        push(10'h3FC, 2'd3, 8'hC0, 8'h40); check("R8", int'(out_sample), 8'hFF);
        // low bits ignored
        push(10'h2A4, 2'd1, 0, 0); first = out_sample;
        push(10'h2A7, 2'd1, 0, 0);
        check("R3", int'(out_sample), int'(first));
        check("R3", int'(out_sample), 8'h54);
        // hold while idle with inputs moving
        idle(5);
        check("R9", int'(out_sample), 8'h54);
        check("R2", int'(out_valid), 0);

        for (int k = 0; k < 2000; k++) begin
            if ($urandom % 4 == 0) idle(1 + $urandom % 3);
            push(10'($urandom), 2'($urandom), 8'($urandom), 8'($urandom));
        end
        idle(3);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule